// File: doc/BRIEF.md
# Channel Alarm and Control Register Bank

This block is the register bank that sits beside a multi-channel serial link core. It gives a processor access, over a simple request/acknowledge bus, to 8-bit registers of three kinds. Live per-channel status bytes are read-only. Alarm registers latch enabled alarm events and clear when they are read. Enable and control registers can be read and written. Each of up to eight link channels (two groups of four lanes) reports two raw alarm events: out-of-frame and parity-check error. The block latches an event only when its enable bit is set. It gathers each channel's latched alarms into one summary bit and raises a level-sensitive interrupt while any summary bit is set.

A bus transfer is handled by a small state machine with states S_IDLE, S_READ and S_WRITE. From S_IDLE, a request with the write flag set takes the transition IDLE_TO_WRITE, and a request without it takes IDLE_TO_READ. S_READ and S_WRITE each last one cycle and return through RESP_TO_IDLE. The acknowledge and the read data are valid during that one response cycle. The bus parity line is not used: write parity is ignored and read parity is always 0. A parameter removes channels for a reduced-channel build. A removed channel's window reads as zero and ignores writes.

Top module: `alm_regbank`

## Requirements
- R1: After reset, every enable, control and alarm register is 0, `ctrl_out` is 0 and `irq` is low.
- R2: A request sampled while idle is answered with `bus_ack` high in exactly the next cycle, and `bus_rdata` is valid in that cycle. `bus_ack` is low in the cycle after that.
- R3: `bus_rpar` is always 0, and the value of `bus_wpar` has no effect on what a write stores.
- R4: Channel i = group*4 + lane has its window at 0x800 + group*0x100 + lane*0x10. Register offset 0 holds the alarms (bit0 out-of-frame, bit1 parity error). Offset 1 holds the enables (bit0 and bit1 stored, bits 7:2 read 0). Offset 2 is an 8-bit control register that drives `ctrl_out[8i+7:8i]`. Offset 3 is the live `stat_in[8i+7:8i]` byte.
- R5: A raw alarm input sets its alarm bit only at a clock edge where the matching enable bit is 1.
- R6: Reading a channel's alarm register returns its bits and then clears them. An enabled event that arrives in the cycle the clear takes effect remains set.
- R7: The summary register at 0xA00 has bit i set when channel i has any latched alarm. Reading the summary register does not clear it.
- R8: `irq` is high exactly while any summary bit is set, and it falls only after the last latched alarm is cleared.
- R9: Writes to the alarm, status and summary registers and to unmapped addresses are ignored. Unmapped addresses read 0x00.
- R10: A channel whose bit in `PRESENT_MASK` is 0 reads 0 at every offset, ignores writes, never latches alarms and never sets its summary bit.
- R11: `oof_out` and `perr_out` always equal `oof_raw` and `perr_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Transfer request, one cycle, while idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Write parity (ignored) |
| bus_ack | output | 1 | Response cycle marker |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_rpar | output | 1 | Read parity, constant 0 |
| oof_raw | input | 8 | Raw out-of-frame event per channel |
| perr_raw | input | 8 | Raw parity-error event per channel |
| stat_in | input | 64 | Live status byte per channel |
| ctrl_out | output | 64 | Control byte per channel |
| oof_out | output | 8 | Pass-through of oof_raw |
| perr_out | output | 8 | Pass-through of perr_raw |
| irq | output | 1 | Level interrupt, any alarm latched |

## Verification
The assertions assume a single requester that raises `bus_req` only while `bus_ack` is low, and that raw alarm inputs change only between clock edges. The interrupt-rise property also assumes the enable registers are changed only by bus writes. The stimulus drives every input on the falling edge. It waits for the full response before it issues the next request, and it keeps each raw alarm pulse one cycle wide unless a pulse has to line up with the clear-on-read cycle. Two instances share the same stimulus: one with every channel present and one reduced to lanes C and D. This exercises the removed-channel behaviour under the same inputs.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NGRP  = 2;
    localparam int NLANE = 4;
    localparam int NCH   = NGRP * NLANE;
    localparam int CW    = $clog2(NCH);
    localparam int DW    = 8;
    localparam int AW    = 12;
    localparam int NALM  = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } bus_st_e;

    localparam logic [3:0] OFS_ALARM  = 4'd0;
    localparam logic [3:0] OFS_ENABLE = 4'd1;
    localparam logic [3:0] OFS_CTRL   = 4'd2;
    localparam logic [3:0] OFS_STAT   = 4'd3;
    localparam logic [AW-1:0] SUM_ADDR = 12'hA00;

    typedef struct packed {
        logic          chan_hit;
        logic [CW-1:0] chan;
        logic [3:0]    ofs;
        logic          sum_hit;
    } dec_t;

    // channel window: 0x800 + group*0x100 + lane*0x10 + offset
    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        d.chan_hit = (a[11:9] == 3'b100) && (a[7:6] == 2'b00);
        d.chan     = {a[8], a[5:4]};
        d.ofs      = a[3:0];
        d.sum_hit  = (a == SUM_ADDR);
        return d;
    endfunction
endpackage

// File: rtl/alm_bus_fsm.sv
module alm_bus_fsm
    import alm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          ack,
    output logic          rd_go,
    output logic          wr_go
);
    bus_st_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st <= st_nx;
            if (st == S_IDLE && req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    always_comb begin
        st_nx = S_IDLE;
        unique case (st)
            S_IDLE:  st_nx = req ? (we ? S_WRITE : S_READ) : S_IDLE;
            S_READ:  st_nx = S_IDLE;
            S_WRITE: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ack   = 1'b0;
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_READ:  begin ack = 1'b1; rd_go = 1'b1; end
            S_WRITE: begin ack = 1'b1; wr_go = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/alm_chan.sv
module alm_chan
    import alm_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oof,
    input  logic          perr,
    input  logic [DW-1:0] stat,
    input  logic          wr_en,
    input  logic [3:0]    ofs,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl,
    output logic          summ,
    output logic          en_oof,
    output logic          en_perr
);
    if (PRESENT) begin : g_live
        logic [NALM-1:0] alm_q, en_q;
        logic [DW-1:0]   ctrl_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alm_q  <= '0;
                en_q   <= '0;
                ctrl_q <= '0;
            end else begin
                // set wins over clear so a colliding event is kept
                alm_q <= (alm_q & ~{NALM{rd_clr}}) | ({perr, oof} & en_q);
                if (wr_en && ofs == OFS_ENABLE) en_q   <= wdata[NALM-1:0];
                if (wr_en && ofs == OFS_CTRL)   ctrl_q <= wdata;
            end
        end

        always_comb begin
            unique case (ofs)
                OFS_ALARM:  rdata = {{(DW-NALM){1'b0}}, alm_q};
                OFS_ENABLE: rdata = {{(DW-NALM){1'b0}}, en_q};
                OFS_CTRL:   rdata = ctrl_q;
                OFS_STAT:   rdata = stat;
                default:    rdata = '0;
            endcase
        end

        assign ctrl    = ctrl_q;
        assign summ    = |alm_q;
        assign en_oof  = en_q[0];
        assign en_perr = en_q[1];
    end else begin : g_absent
        assign rdata   = '0;
        assign ctrl    = '0;
        assign summ    = 1'b0;
        assign en_oof  = 1'b0;
        assign en_perr = 1'b0;
    end
endmodule

// File: rtl/alm_regbank.sv
module alm_regbank
    import alm_pkg::*;
#(
    parameter logic [NCH-1:0] PRESENT_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wpar,
    output logic              bus_ack,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_rpar,
    input  logic [NCH-1:0]    oof_raw,
    input  logic [NCH-1:0]    perr_raw,
    input  logic [NCH*DW-1:0] stat_in,
    output logic [NCH*DW-1:0] ctrl_out,
    output logic [NCH-1:0]    oof_out,
    output logic [NCH-1:0]    perr_out,
    output logic              irq
);
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic           rd_go, wr_go;
    dec_t           dec;
    logic [NCH-1:0] sel_ch, rd_clr, wr_ch, summ_v, en_oof_v, en_perr_v;
    logic [DW-1:0]  ch_rd [NCH];
    logic           unused_wpar;

    alm_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ack     (bus_ack),
        .rd_go   (rd_go),
        .wr_go   (wr_go)
    );

    assign dec = decode(addr_q);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign sel_ch[i] = dec.chan_hit && (dec.chan == CW'(i));
        assign rd_clr[i] = rd_go && sel_ch[i] && (dec.ofs == OFS_ALARM);
        assign wr_ch[i]  = wr_go && sel_ch[i];

        alm_chan #(.PRESENT(PRESENT_MASK[i])) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .oof     (oof_raw[i]),
            .perr    (perr_raw[i]),
            .stat    (stat_in[i*DW +: DW]),
            .wr_en   (wr_ch[i]),
            .ofs     (dec.ofs),
            .wdata   (wdata_q),
            .rd_clr  (rd_clr[i]),
            .rdata   (ch_rd[i]),
            .ctrl    (ctrl_out[i*DW +: DW]),
            .summ    (summ_v[i]),
            .en_oof  (en_oof_v[i]),
            .en_perr (en_perr_v[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            if (dec.chan_hit)     bus_rdata = ch_rd[dec.chan];
            else if (dec.sum_hit) bus_rdata = DW'(summ_v);
        end
    end

    assign unused_wpar = bus_wpar;
    assign bus_rpar    = 1'b0;
    assign irq         = |summ_v;
    assign oof_out     = oof_raw;
    assign perr_out    = perr_raw;
endmodule

// File: rtl/alm_regbank_chk.sv
module alm_regbank_chk
    import alm_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_ack,
    input logic           bus_rpar,
    input logic           irq,
    input logic [NCH-1:0] oof_raw,
    input logic [NCH-1:0] perr_raw,
    input logic [NCH-1:0] en_oof_v,
    input logic [NCH-1:0] en_perr_v
);
    p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_ack);

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_rpar_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rpar == 1'b0);

    p_irq_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|((oof_raw & en_oof_v) | (perr_raw & en_perr_v))));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !bus_ack |=> irq);

    p_irq_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

bind alm_regbank alm_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rpar  (bus_rpar),
    .irq       (irq),
    .oof_raw   (oof_raw),
    .perr_raw  (perr_raw),
    .en_oof_v  (en_oof_v),
    .en_perr_v (en_perr_v)
);

// File: tb/alm_regbank_test.sv
module alm_regbank_test;
    import alm_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              bus_req, bus_we, bus_wpar;
    logic [AW-1:0]     bus_addr;
    logic [DW-1:0]     bus_wdata;
    logic [NCH-1:0]    oof_raw, perr_raw;
    logic [NCH*DW-1:0] stat_in;

    logic              ack_f, rpar_f, irq_f, ack_l, rpar_l, irq_l;
    logic [DW-1:0]     rdata_f, rdata_l;
    logic [NCH*DW-1:0] ctrl_f, ctrl_l;
    logic [NCH-1:0]    oof_f, perr_f, oof_l, perr_l;

    int   n_chk = 0;
    int   n_bad = 0;
    logic rd_flag = 1'b0;
    logic [DW-1:0] q_ef[$];
    logic [DW-1:0] q_el[$];
    string         q_tag[$];

    alm_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
        .bus_ack(ack_f), .bus_rdata(rdata_f), .bus_rpar(rpar_f),
        .oof_raw(oof_raw), .perr_raw(perr_raw), .stat_in(stat_in),
        .ctrl_out(ctrl_f), .oof_out(oof_f), .perr_out(perr_f), .irq(irq_f)
    );

    alm_regbank #(.PRESENT_MASK(8'hCC)) uut_lite (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
        .bus_ack(ack_l), .bus_rdata(rdata_l), .bus_rpar(rpar_l),
        .oof_raw(oof_raw), .perr_raw(perr_raw), .stat_in(stat_in),
        .ctrl_out(ctrl_l), .oof_out(oof_l), .perr_out(perr_l), .irq(irq_l)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rd_flag && ack_f) begin
            if (q_ef.size() == 0) begin
                check("R2 unexpected read response", 64'(rdata_f), 64'hFFFF);
            end else begin
                automatic string    t  = q_tag.pop_front();
                automatic logic [7:0] ef = q_ef.pop_front();
                automatic logic [7:0] el = q_el.pop_front();
                check({t, " full"}, 64'(rdata_f), 64'(ef));
                check({t, " reduced"}, 64'(rdata_l), 64'(el));
                check("R3 read parity low", 64'({rpar_f, rpar_l}), 64'd0);
            end
        end
    end

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic par, input int coll);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_wpar = par;
        rd_flag = !we;
        @(negedge clk);
        bus_req = 1'b0;
        check("R2 ack in response cycle", 64'({ack_f, ack_l}), 64'd3);
        if (coll >= 0) oof_raw[coll] = 1'b1;
        @(negedge clk);
        check("R2 ack single cycle", 64'({ack_f, ack_l}), 64'd0);
        if (coll >= 0) oof_raw[coll] = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] ef, input logic [DW-1:0] el,
                      input string tag);
        q_ef.push_back(ef); q_el.push_back(el); q_tag.push_back(tag);
        access(1'b0, a, 8'h00, 1'b0, -1);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic par);
        access(1'b1, a, d, par, -1);
    endtask

    task automatic pulse(input logic is_perr, input int ch);
        @(negedge clk);
        if (is_perr) perr_raw[ch] = 1'b1; else oof_raw[ch] = 1'b1;
        @(negedge clk);
        if (is_perr) perr_raw[ch] = 1'b0; else oof_raw[ch] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_wpar = 1'b0;
        bus_addr = '0; bus_wdata = '0; oof_raw = '0; perr_raw = '0;
        for (int i = 0; i < NCH; i++) stat_in[i*DW +: DW] = 8'h10 + 8'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", 64'({irq_f, irq_l}), 64'd0);
        check("R1 ctrl_out after reset", ctrl_f, 64'd0);
        rd(12'h802, 8'h00, 8'h00, "R1 ctrl ch0 reset");
        rd(12'h910, 8'h00, 8'h00, "R1 alarm ch5 reset");
        rd(12'hA00, 8'h00, 8'h00, "R1 summary reset");

        // R4 control read/write, R3 parity ignored
        wr(12'h822, 8'h5A, 1'b0);
        rd(12'h822, 8'h5A, 8'h5A, "R4 ctrl ch2 readback");
        check("R4 ctrl_out ch2", 64'(ctrl_f[23:16]), 64'h5A);
        wr(12'h822, 8'hA5, 1'b1);
        rd(12'h822, 8'hA5, 8'hA5, "R3 write with parity 1 stored");

        // R10 absent channel, R4 status map
        wr(12'h802, 8'h33, 1'b0);
        rd(12'h802, 8'h33, 8'h00, "R10 ctrl ch0 absent in reduced");
        check("R10 reduced ctrl_out ch0", 64'(ctrl_l[7:0]), 64'h00);
        rd(12'h803, 8'h10, 8'h00, "R10 status ch0 absent in reduced");
        rd(12'h933, 8'h17, 8'h17, "R4 status ch7");
        wr(12'h811, 8'hFF, 1'b0);
        rd(12'h811, 8'h03, 8'h00, "R4 enable ch1 two bits");

        // R5 enable gating, R8 irq, R6 clear on read
        wr(12'h831, 8'h01, 1'b0);
        @(negedge clk);
        oof_raw[3] = 1'b1; perr_raw[3] = 1'b1;
        @(negedge clk);
        oof_raw[3] = 1'b0; perr_raw[3] = 1'b0;
        check("R8 irq with latched alarm", 64'({irq_f, irq_l}), 64'd3);
        rd(12'h830, 8'h01, 8'h01, "R5 only enabled bit latched ch3");
        rd(12'h830, 8'h00, 8'h00, "R6 alarm cleared by read ch3");
        check("R8 irq low after clear", 64'({irq_f, irq_l}), 64'd0);

        // R11 pass-through
        @(negedge clk);
        oof_raw = 8'hA5; perr_raw = 8'h3C;
        #1;
        check("R11 oof pass-through", 64'({oof_f, oof_l}), 64'hA5A5);
        check("R11 perr pass-through", 64'({perr_f, perr_l}), 64'h3C3C);
        @(negedge clk);
        oof_raw = '0; perr_raw = '0;

        // R7 summary
        wr(12'h921, 8'h03, 1'b0);
        pulse(1'b1, 6);
        rd(12'hA00, 8'h40, 8'h40, "R7 summary bit ch6");
        rd(12'hA00, 8'h40, 8'h40, "R7 summary not cleared by read");
        check("R8 irq from ch6", 64'({irq_f, irq_l}), 64'd3);
        rd(12'h920, 8'h02, 8'h02, "R6 ch6 parity alarm read");
        rd(12'hA00, 8'h00, 8'h00, "R7 summary after channel clear");

        // R6 event colliding with clear
        q_ef.push_back(8'h00); q_el.push_back(8'h00); q_tag.push_back("R6 read during collision");
        access(1'b0, 12'h830, 8'h00, 1'b0, 3);
        rd(12'h830, 8'h01, 8'h01, "R6 colliding event kept");
        rd(12'h830, 8'h00, 8'h00, "R6 cleared after second read");

        // R9 ignored writes, unmapped reads
        wr(12'h830, 8'hFF, 1'b0);
        rd(12'h830, 8'h00, 8'h00, "R9 alarm register write ignored");
        wr(12'h833, 8'hFF, 1'b0);
        rd(12'h833, 8'h13, 8'h13, "R9 status write ignored");
        wr(12'h804, 8'hFF, 1'b0);
        rd(12'h804, 8'h00, 8'h00, "R9 unmapped offset");
        wr(12'hA00, 8'hFF, 1'b0);
        rd(12'hA00, 8'h00, 8'h00, "R9 summary write ignored");
        rd(12'hB00, 8'h00, 8'h00, "R9 unmapped region");
        rd(12'h8C2, 8'h00, 8'h00, "R9 hole between windows");

        // R10 absent channel never alarms
        wr(12'h801, 8'h01, 1'b0);
        pulse(1'b0, 0);
        check("R10 irq full vs reduced", 64'({irq_f, irq_l}), 64'b10);
        rd(12'hA00, 8'h01, 8'h00, "R10 summary ch0");
        rd(12'h800, 8'h01, 8'h00, "R10 alarm ch0");
        check("R8 irq after final clear", 64'({irq_f, irq_l}), 64'd0);

        @(negedge clk);
        check("R2 all responses seen", 64'(q_ef.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule